// File: doc/BRIEF.md
# Byte Register Access Unit with Address-Encoded Read-Modify-Write

This block is the control register file that a host sees through a byte-wide, memory-mapped port on a network adapter attachment. Each access carries a 9-bit address. The block splits that address into three fields: a register index, an operation code and an area selector. One access can store the data byte, AND it into a register, OR it into a register, or read a register back. Because the operation rides in the address, the host sets or clears single bits with one store and no read beforehand.

The control area holds even/odd register pairs. These cover shared-memory relocation, host interrupt status, timer control and value, and memory paging. Two read-only identification areas return an encoded adapter address and a fixed test pattern. Any access that names a reserved area or an unimplemented register, and any modify access to a read-only area, is refused. The block then pulses an error output and latches an access-error bit in the interrupt status register. Two fields are decoded for the rest of the attachment: the shared-memory base address and the paging enable.

Top module: `brau_top`

## Requirements
- R1: The address splits as index = bits 4:0, operation = bits 6:5 (00 store, 01 AND, 10 OR, 11 read), area = bits 8:7 (00 control, 01 reserved, 10 address ID, 11 test ID). A store to an implemented control register (indices 0, 1, 8, 12, 13, 14, 15, 24) replaces its contents with the data byte.
- R2: An AND access sets the register to the old value AND the data, in the same cycle. The read data returns 0x00 in the cycle after.
- R3: An OR access sets the register to the old value OR the data, in the same cycle. The read data returns 0x00 in the cycle after.
- R4: A read access returns the register value on the read data output one clock after the access is presented, and leaves the register unchanged. In every cycle that does not follow a read, the read data output is 0x00.
- R5: In the control area, an access of any operation to an unimplemented index reads 0x00 and changes no register. This includes index 25, the unused odd paging register. The error output is high for exactly the one cycle after the access.
- R6: Any access to the reserved area (area 01) reads 0x00, changes nothing and pulses the error output for one cycle.
- R7: A read in area 10 returns {4'h0, ID_WORD[4*k+3:4*k]} with k = index bits 3:0. Store, AND and OR accesses to area 10 or 11 are refused: they pulse the error output and change no register.
- R8: A read in area 11 returns 8'hA5 XOR the 5-bit index.
- R9: Every refused access sets bit 2 of the even interrupt status register (index 8). The bit stays set until the host clears it with a store or an AND access.
- R10: The shared-memory base output equals bits 7:1 of the even relocation register (index 0), placed at address bits 19:13, with bits 12:0 zero.
- R11: Bits 3:2 of the odd relocation register (index 1) always read the SIZE_CODE parameter (00 8K, 01 16K, 10 32K, 11 64K), whatever is written. Its other bits are writable.
- R12: The paging enable output is high exactly when bits 7 and 6 of the even paging register (index 24) are both 1.
- R13: After reset every register reads 0x00 except the size field of index 1. The read data, error, base and paging outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe, one access per cycle |
| accAddr | input | 9 | Access address: index, operation, area |
| wrData | input | 8 | Data byte for store, AND and OR |
| rdData | output | 8 | Registered read data, zero when no read |
| accErr | output | 1 | One-cycle pulse after a refused access |
| memBase | output | 20 | Decoded shared-memory base address |
| pagingOn | output | 1 | Shared-memory paging enable |

## Verification
The bench builds the block with SIZE_CODE = 2'b10 and ID_WORD = 64'h0123_4567_89AB_CDEF, so that every identification nibble is distinct and the size field is not zero. With these values, one sweep covers all 512 combinations of operation, area and index. A model in the bench predicts each read byte and each error pulse, using the AND and OR results of earlier steps. Refused accesses in the sweep leave the error bit set before later reads of the interrupt status register. Directed steps then drive the base address and paging decodes to both extremes, and clear the error bit.

// File: rtl/brau_pkg.sv
package brau_pkg;
  localparam int IDX_W = 5;
  localparam int AREA_W = 2;
  localparam int OP_W = 2;
  localparam int ADDR_W = IDX_W + OP_W + AREA_W;
  localparam int BYTE_W = 8;

  localparam int IDX_RELOC_EVEN = 0;
  localparam int IDX_RELOC_ODD = 1;
  localparam int IDX_ISR_EVEN = 8;
  localparam int IDX_TMR_VAL = 14;
  localparam int IDX_PAGE_EVEN = 24;
  localparam int ERR_BIT = 2;

  typedef enum logic [OP_W-1:0] {
    OP_STORE = 2'b00,
    OP_AND   = 2'b01,
    OP_OR    = 2'b10,
    OP_READ  = 2'b11
  } accOp_e;

  typedef enum logic [AREA_W-1:0] {
    AREA_CTRL   = 2'b00,
    AREA_RSVD   = 2'b01,
    AREA_IDADDR = 2'b10,
    AREA_IDTEST = 2'b11
  } area_e;

  typedef struct packed {
    logic             modify;
    logic             readReg;
    logic             readId;
    logic             readTest;
    logic             flagErr;
    accOp_e           op;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/brau_ctrl.sv
module brau_ctrl
  import brau_pkg::*;
#(
  parameter logic [31:0] IMPL_MASK = 32'h0100_F103
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output strobe_t           strb
);
  area_e            area;
  accOp_e           op;
  logic [IDX_W-1:0] idx;

  assign idx  = accAddr[IDX_W-1:0];
  assign op   = accOp_e'(accAddr[IDX_W+OP_W-1:IDX_W]);
  assign area = area_e'(accAddr[ADDR_W-1:IDX_W+OP_W]);

  always_comb begin
    strb     = '0;
    strb.op  = op;
    strb.idx = idx;
    if (accValid) begin
      unique case (area)
        AREA_CTRL: begin
          if (IMPL_MASK[idx]) begin
            if (op == OP_READ) strb.readReg = 1'b1;
            else               strb.modify  = 1'b1;
          end else begin
            strb.flagErr = 1'b1;
          end
        end
        AREA_RSVD: strb.flagErr = 1'b1;
        AREA_IDADDR: begin
          if (op == OP_READ) strb.readId  = 1'b1;
          else               strb.flagErr = 1'b1;
        end
        AREA_IDTEST: begin
          if (op == OP_READ) strb.readTest = 1'b1;
          else               strb.flagErr  = 1'b1;
        end
        default: strb.flagErr = 1'b1;
      endcase
    end
  end

  // R5
  oneAction_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.modify, strb.readReg, strb.readId, strb.readTest, strb.flagErr}));

  // R1
  idleQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !(strb.modify || strb.readReg || strb.readId || strb.readTest || strb.flagErr));
endmodule

// File: rtl/brau_datapath.sv
module brau_datapath
  import brau_pkg::*;
#(
  parameter logic [31:0] IMPL_MASK = 32'h0100_F103,
  parameter logic [1:0]  SIZE_CODE = 2'b00,
  parameter logic [63:0] ID_WORD   = 64'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] wData,
  output logic [BYTE_W-1:0] rdData,
  output logic              accErr,
  output logic [19:0]       memBase,
  output logic              pagingOn
);
  localparam int NREG = 1 << IDX_W;
  localparam int BASE_LSB = 13;

  logic [NREG-1:0][BYTE_W-1:0] regVal;
  logic [BYTE_W-1:0]           selVal;
  logic [BYTE_W-1:0]           rdNext;

  assign selVal = regVal[strb.idx];

  for (genvar g = 0; g < NREG; g++) begin : gReg
    if (IMPL_MASK[g]) begin : gImpl
      logic [BYTE_W-1:0] q;
      logic [BYTE_W-1:0] nxt;
      logic [BYTE_W-1:0] rstVal;

      always_comb begin
        rstVal = '0;
        if (g == IDX_RELOC_ODD) rstVal[3:2] = SIZE_CODE;
      end

      always_comb begin
        nxt = q;
        if (strb.modify && (strb.idx == IDX_W'(g))) begin
          unique case (strb.op)
            OP_AND:  nxt = q & wData;
            OP_OR:   nxt = q | wData;
            default: nxt = wData;
          endcase
        end
        if (g == IDX_RELOC_ODD) nxt[3:2] = SIZE_CODE;
        if ((g == IDX_ISR_EVEN) && strb.flagErr) nxt[ERR_BIT] = 1'b1;
      end

      always_ff @(posedge clk) begin
        if (!rstN) q <= rstVal;
        else       q <= nxt;
      end

      assign regVal[g] = q;
    end else begin : gAbsent
      assign regVal[g] = '0;
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.readReg)       rdNext = selVal;
    else if (strb.readId)   rdNext = {4'h0, ID_WORD[{strb.idx[3:0], 2'b00} +: 4]};
    else if (strb.readTest) rdNext = 8'hA5 ^ {3'b000, strb.idx};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      accErr <= 1'b0;
    end else begin
      rdData <= rdNext;
      accErr <= strb.flagErr;
    end
  end

  assign memBase  = {regVal[IDX_RELOC_EVEN][7:1], {BASE_LSB{1'b0}}};
  assign pagingOn = &regVal[IDX_PAGE_EVEN][7:6];

  // R9
  errLatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.flagErr) |-> regVal[IDX_ISR_EVEN][ERR_BIT]);

  // R4
  rdIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.readReg || strb.readId || strb.readTest) |-> (rdData == '0));

  // R2
  andMerge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.modify && strb.op == OP_AND && strb.idx == IDX_W'(IDX_TMR_VAL))
      |-> (regVal[IDX_TMR_VAL] == ($past(regVal[IDX_TMR_VAL]) & $past(wData))));

  // R3
  orMerge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.modify && strb.op == OP_OR && strb.idx == IDX_W'(IDX_TMR_VAL))
      |-> (regVal[IDX_TMR_VAL] == ($past(regVal[IDX_TMR_VAL]) | $past(wData))));

  // R4
  readKeeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.readReg) |-> $stable(regVal[IDX_TMR_VAL]));
endmodule

// File: rtl/brau_top.sv
module brau_top
  import brau_pkg::*;
#(
  parameter logic [31:0] IMPL_MASK = 32'h0100_F103,
  parameter logic [1:0]  SIZE_CODE = 2'b00,
  parameter logic [63:0] ID_WORD   = 64'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic [8:0]  accAddr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        accErr,
  output logic [19:0] memBase,
  output logic        pagingOn
);
  strobe_t strb;

  brau_ctrl #(.IMPL_MASK(IMPL_MASK)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accAddr  (accAddr),
    .strb     (strb)
  );

  brau_datapath #(
    .IMPL_MASK (IMPL_MASK),
    .SIZE_CODE (SIZE_CODE),
    .ID_WORD   (ID_WORD)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wData    (wrData),
    .rdData   (rdData),
    .accErr   (accErr),
    .memBase  (memBase),
    .pagingOn (pagingOn)
  );
endmodule

// File: tb/brau_top_test.sv
`timescale 1ns/1ps
module brau_top_test;
  localparam logic [31:0] MASK = 32'h0100_F103;
  localparam logic [1:0]  SIZE = 2'b10;
  localparam logic [63:0] IDW  = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [8:0]  accAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        accErr;
  logic [19:0] memBase;
  logic        pagingOn;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [32];

  always #4 clk = ~clk;

  brau_top #(.IMPL_MASK(MASK), .SIZE_CODE(SIZE), .ID_WORD(IDW)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .wrData(wrData), .rdData(rdData), .accErr(accErr),
    .memBase(memBase), .pagingOn(pagingOn)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [8:0] a, input logic [7:0] d);
    logic [1:0] area = a[8:7];
    logic [1:0] op = a[6:5];
    logic [4:0] idx = a[4:0];
    logic refused;
    logic [7:0] expRd;
    logic [7:0] nv;
    string tag;
    refused = (area == 2'd1) || (area == 2'd0 && !MASK[idx]) || (area >= 2'd2 && op != 2'd3);
    expRd = 8'h00;
    if (!refused && op == 2'd3) begin
      if (area == 2'd0)      expRd = model[idx];
      else if (area == 2'd2) expRd = {4'h0, IDW[{idx[3:0], 2'b00} +: 4]};
      else                   expRd = 8'hA5 ^ {3'b000, idx};
    end
    if (refused)        tag = (area == 2'd1) ? "R6" : (area >= 2'd2) ? "R7" : "R5";
    else if (op == 2'd3) tag = (area == 2'd2) ? "R7" : (area == 2'd3) ? "R8" : "R4";
    else if (op == 2'd0) tag = "R1";
    else if (op == 2'd1) tag = "R2";
    else                 tag = "R3";
    if (!refused && area == 2'd0 && op != 2'd3) begin
      nv = (op == 2'd0) ? d : (op == 2'd1) ? (model[idx] & d) : (model[idx] | d);
      if (idx == 5'd1) nv[3:2] = SIZE;
      model[idx] = nv;
    end
    if (refused) model[8][2] = 1'b1;
    @(negedge clk);
    accValid = 1'b1; accAddr = a; wrData = d;
    @(negedge clk);
    accValid = 1'b0;
    check(rdData == expRd, tag, 32'(rdData), 32'(expRd));
    check(accErr == refused, tag, 32'(accErr), 32'(refused));
    if (refused) begin
      @(negedge clk);
      check(accErr == 1'b0, "R5 pulse length", 32'(accErr), 0);
    end
  endtask

  function automatic logic [8:0] mk(input int area, input int op, input int idx);
    return {2'(area), 2'(op), 5'(idx)};
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    model[1] = {4'h0, SIZE, 2'b00};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(rdData == 8'h00, "R13 rdData", 32'(rdData), 0);
    check(accErr == 1'b0, "R13 accErr", 32'(accErr), 0);
    check(memBase == 20'h0, "R13 memBase", 32'(memBase), 0);
    check(pagingOn == 1'b0, "R13 pagingOn", 32'(pagingOn), 0);
    access(mk(0, 3, 1), 8'h00);   // R11 R13 size field after reset
    access(mk(0, 3, 8), 8'h00);   // R13 status clear after reset

    // sweep of every operation, area and index
    for (int op = 0; op < 4; op++)
      for (int area = 0; area < 4; area++)
        for (int idx = 0; idx < 32; idx++)
          access(mk(area, op, idx), 8'h5A ^ 8'(idx * 37) ^ 8'(op << 4));

    // R10 base decode from sweep state and extremes
    check(memBase == {model[0][7:1], 13'h0}, "R10", 32'(memBase), 32'({model[0][7:1], 13'h0}));
    access(mk(0, 0, 0), 8'hFF);
    check(memBase == 20'hFE000, "R10 max", 32'(memBase), 32'h000FE000);
    access(mk(0, 1, 0), 8'h03);
    check(memBase == 20'h02000, "R10 low bit", 32'(memBase), 32'h00002000);

    // R11 size bits resist writes
    access(mk(0, 0, 1), 8'hFF);
    access(mk(0, 3, 1), 8'h00);
    access(mk(0, 1, 1), 8'h00);
    access(mk(0, 3, 1), 8'h00);

    // R12 paging decode
    access(mk(0, 0, 24), 8'hC0);
    check(pagingOn == 1'b1, "R12 on", 32'(pagingOn), 1);
    access(mk(0, 1, 24), 8'h80);
    check(pagingOn == 1'b0, "R12 half", 32'(pagingOn), 0);
    access(mk(0, 2, 24), 8'h40);
    check(pagingOn == 1'b1, "R12 or", 32'(pagingOn), 1);
    access(mk(0, 0, 25), 8'hFF);  // R5 odd paging unused
    access(mk(0, 3, 25), 8'h00);

    // R9 error bit sticky, cleared by AND
    access(mk(1, 0, 3), 8'h11);
    access(mk(0, 3, 8), 8'h00);
    access(mk(0, 2, 8), 8'h41);
    access(mk(0, 1, 8), 8'hFB);
    access(mk(0, 3, 8), 8'h00);
    check(model[8][2] == 1'b0, "R9 cleared model", 32'(model[8][2]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule